// File: doc/BRIEF.md
# Interval Timer Host Command Decoder

This block is the host-facing front end of a three-channel interval timer. It takes the asynchronous host bus (active-low chip select, read and write strobes, a two-bit address and an eight-bit data byte), brings the strobes into the system clock domain and turns every completed bus access into single-cycle command pulses for the timer channels. The counting logic and the byte sequencing inside each channel sit behind it and are not part of it.

A write to one of the three channel addresses becomes a data-write pulse for that channel, with the byte presented on a registered data output. A write to the control address is classified by its upper bits as a mode setup for one channel, a count snapshot request for one channel, or a multi-channel read-back request. A read-back request can fan out count-latch and status-latch pulses to any subset of the channels in the same cycle. On the read side the block selects the addressed channel's byte onto the output with an enable. When the strobe is released it tells that channel that the byte has been consumed.

Top module: `timer_cmd_decoder`

## Requirements
- R1: Address 0, 1 and 2 select channel 0, 1 and 2, and address 3 selects the control register. A write to address k yields exactly one `chan_wr` pulse on bit k and presents the written byte on `wdata` while that pulse is high.
- R2: While `cs_n` is high, both strobes are ignored: no pulse of any kind is produced and `rdata_oe` stays low.
- R3: `rdata_oe` is high only while `cs_n` and `rd_n` are both low and the address is 0 to 2. While it is high, `rdata` equals the byte of the addressed channel. Otherwise `rdata` is 0, and this includes any read at address 3.
- R4: A control byte whose bits [7:6] name a channel (00, 01 or 10) and whose bits [5:4] are not 00 gives one `prog` pulse on that channel. `ctl_access` then holds bits [5:4], `ctl_mode` holds the mode from bits [3:1], and `ctl_bcd` holds bit 0.
- R5: A control byte with bits [7:6] naming a channel and bits [5:4] = 00 gives one `latch_cnt` pulse on that channel only, and no `prog` pulse.
- R6: A control byte with bits [7:6] = 11 is a read-back request. Bits 3, 2 and 1 select channels 2, 1 and 0. Bit 5 low requests a `latch_cnt` pulse and bit 4 low requests a `latch_sts` pulse on every selected channel, all in the same cycle.
- R7: A read-back request with no channel bit set, or with bits 5 and 4 both high, produces no pulse.
- R8: Mode codes 6 and 7 in bits [3:1] are reported on `ctl_mode` as 2 and 3. Codes 0 to 5 pass through unchanged.
- R9: Each falling edge of `wr_n` under chip select produces its command pulses exactly once, each lasting one clock cycle, however long the strobe is held.
- R10: A read of channel k produces one `chan_rd` pulse on bit k only after `rd_n` returns high, and never during the strobe. A read at address 3 produces none.
- R11: After reset all pulse outputs are low, `wdata` is 0 and the control fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| addr | input | 2 | Host address: channel 0..2 or control (3) |
| din | input | 8 | Host write byte |
| chan_rdata | input | 24 | Read bytes from the channels, channel k in bits [8k+7:8k] |
| rdata | output | 8 | Read byte toward the host |
| rdata_oe | output | 1 | Read data output enable |
| wdata | output | 8 | Registered write byte for the channels |
| chan_wr | output | 3 | Per-channel data-write pulse |
| chan_rd | output | 3 | Per-channel byte-consumed pulse |
| prog | output | 3 | Per-channel mode setup pulse |
| latch_cnt | output | 3 | Per-channel count snapshot pulse |
| latch_sts | output | 3 | Per-channel status snapshot pulse |
| ctl_access | output | 2 | Access field of the last mode setup |
| ctl_mode | output | 3 | Normalised mode of the last mode setup |
| ctl_bcd | output | 1 | Decimal-count flag of the last mode setup |

## Verification
A misclassified control byte shows up at once as a pulse on the wrong vector or the wrong channel, two cycles after the synchronised strobe edge. A stale edge detector shows up as a missing or repeated pulse when a strobe is held long. A wrong read-address capture shows up as a consumed-byte pulse on a channel other than the one whose byte was driven out. Because every pulse is a single cycle, the bench counts pulses per channel over each whole access, so both a lost pulse and a duplicated pulse are caught.

// File: rtl/timer_cmd_pkg.sv
package timer_cmd_pkg;
   localparam int BYTE_W = 8;
   localparam logic [1:0] CTRL_ADDR = 2'b11;
   localparam logic [1:0] SEL_READBACK = 2'b11;
   localparam logic [1:0] ACC_SNAPSHOT = 2'b00;

   // Fold the two aliased mode codes onto their canonical values.
   function automatic logic [2:0] fold_mode(input logic [2:0] m);
      return m[1] ? {1'b0, m[1:0]} : m;
   endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_raw,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("strobe_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES:0] shr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shr <= '0;
      else        shr <= {shr[STAGES-1:0], active_raw};
   end

   assign rise = shr[STAGES-1] & ~shr[STAGES];
   assign fall = ~shr[STAGES-1] & shr[STAGES];
endmodule

// File: rtl/cmd_classify.sv
module cmd_classify
   import timer_cmd_pkg::*;
#(
   parameter int NCH = 3
) (
   input  logic [1:0]        addr,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [NCH-1:0]    is_wr,
   output logic [NCH-1:0]    is_prog,
   output logic [NCH-1:0]    is_lcnt,
   output logic [NCH-1:0]    is_lsts
);
   logic [1:0] sel, acc;
   logic       to_ctrl, readback, snapshot;

   assign sel      = byte_in[7:6];
   assign acc      = byte_in[5:4];
   assign to_ctrl  = (addr == CTRL_ADDR);
   assign readback = to_ctrl && (sel == SEL_READBACK);
   assign snapshot = to_ctrl && !readback && (acc == ACC_SNAPSHOT);

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         logic named;
         assign named      = (sel == 2'(i));
         assign is_wr[i]   = !to_ctrl && (addr == 2'(i));
         assign is_prog[i] = to_ctrl && !readback && !snapshot && named;
         assign is_lcnt[i] = (snapshot && named) ||
                             (readback && byte_in[1+i] && !byte_in[5]);
         assign is_lsts[i] = readback && byte_in[1+i] && !byte_in[4];
      end
   endgenerate
endmodule

// File: rtl/read_mux.sv
module read_mux
   import timer_cmd_pkg::*;
#(
   parameter int NCH = 3
) (
   input  logic                  cs_n,
   input  logic                  rd_n,
   input  logic [1:0]            addr,
   input  logic [NCH*BYTE_W-1:0] chan_rdata,
   output logic [BYTE_W-1:0]     rdata,
   output logic                  rdata_oe
);
   logic hit;

   always_comb begin
      hit   = 1'b0;
      rdata = '0;
      for (int i = 0; i < NCH; i++) begin
         if (addr == 2'(i)) begin
            hit = 1'b1;
            if (!cs_n && !rd_n) rdata = chan_rdata[i*BYTE_W +: BYTE_W];
         end
      end
   end

   assign rdata_oe = !cs_n && !rd_n && hit;
endmodule

// File: rtl/timer_cmd_decoder.sv
module timer_cmd_decoder
   import timer_cmd_pkg::*;
#(
   parameter int NCH         = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_n,
   input  logic                  rd_n,
   input  logic                  wr_n,
   input  logic [1:0]            addr,
   input  logic [7:0]            din,
   input  logic [NCH*8-1:0]      chan_rdata,
   output logic [7:0]            rdata,
   output logic                  rdata_oe,
   output logic [7:0]            wdata,
   output logic [NCH-1:0]        chan_wr,
   output logic [NCH-1:0]        chan_rd,
   output logic [NCH-1:0]        prog,
   output logic [NCH-1:0]        latch_cnt,
   output logic [NCH-1:0]        latch_sts,
   output logic [1:0]            ctl_access,
   output logic [2:0]            ctl_mode,
   output logic                  ctl_bcd
);
   generate
      if (NCH < 1 || NCH > 3) begin : g_bad_nch
         $error("NCH must be 1 to 3: two address bits with one code for control");
      end
   endgenerate

   logic wr_rise, wr_fall_unused, rd_rise, rd_fall;
   logic [NCH-1:0] c_wr, c_prog, c_lcnt, c_lsts;
   logic [1:0] rd_addr_q;

   strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .active_raw(!cs_n && !wr_n),
      .rise(wr_rise), .fall(wr_fall_unused));

   strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .active_raw(!cs_n && !rd_n),
      .rise(rd_rise), .fall(rd_fall));

   cmd_classify #(.NCH(NCH)) u_cls (
      .addr(addr), .byte_in(din),
      .is_wr(c_wr), .is_prog(c_prog), .is_lcnt(c_lcnt), .is_lsts(c_lsts));

   read_mux #(.NCH(NCH)) u_rmux (
      .cs_n(cs_n), .rd_n(rd_n), .addr(addr), .chan_rdata(chan_rdata),
      .rdata(rdata), .rdata_oe(rdata_oe));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_wr    <= '0;
         prog       <= '0;
         latch_cnt  <= '0;
         latch_sts  <= '0;
         wdata      <= '0;
         ctl_access <= '0;
         ctl_mode   <= '0;
         ctl_bcd    <= 1'b0;
      end else begin
         chan_wr   <= wr_rise ? c_wr   : '0;
         prog      <= wr_rise ? c_prog : '0;
         latch_cnt <= wr_rise ? c_lcnt : '0;
         latch_sts <= wr_rise ? c_lsts : '0;
         if (wr_rise && |c_wr) wdata <= din;
         if (wr_rise && |c_prog) begin
            ctl_access <= din[5:4];
            ctl_mode   <= fold_mode(din[3:1]);
            ctl_bcd    <= din[0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_addr_q <= CTRL_ADDR;
         chan_rd   <= '0;
      end else begin
         if (rd_rise) rd_addr_q <= addr;
         for (int i = 0; i < NCH; i++)
            chan_rd[i] <= rd_fall && (rd_addr_q == 2'(i));
      end
   end
endmodule

// File: rtl/timer_cmd_decoder_chk.sv
module timer_cmd_decoder_chk #(
   parameter int NCH = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           cs_n,
   input logic           rd_n,
   input logic [1:0]     addr,
   input logic [7:0]     rdata,
   input logic           rdata_oe,
   input logic [NCH-1:0] chan_wr,
   input logic [NCH-1:0] chan_rd,
   input logic [NCH-1:0] prog,
   input logic [NCH-1:0] latch_cnt,
   input logic [NCH-1:0] latch_sts,
   input logic [2:0]     ctl_mode
);
   AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_wr)); // R1
   AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> (!cs_n && !rd_n)); // R2
   AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_oe |-> (rdata == 8'h00)); // R3
   AST_CTRL_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 2'b11) |-> !rdata_oe); // R3
   AST_PROG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(prog)); // R4
   AST_PROG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (|prog) |-> !(|latch_cnt) && !(|latch_sts) && !(|chan_wr)); // R5
   AST_MODE_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_mode <= 3'd5); // R8
   AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (|{chan_wr, prog, latch_cnt, latch_sts}) |=> !(|{chan_wr, prog, latch_cnt, latch_sts})); // R9
   AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_rd)); // R10
   AST_RD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (|chan_rd) |-> !(|$past(chan_rd))); // R10
endmodule

bind timer_cmd_decoder timer_cmd_decoder_chk #(.NCH(NCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .addr(addr),
   .rdata(rdata), .rdata_oe(rdata_oe), .chan_wr(chan_wr), .chan_rd(chan_rd),
   .prog(prog), .latch_cnt(latch_cnt), .latch_sts(latch_sts), .ctl_mode(ctl_mode));

// File: tb/tb_timer_cmd_decoder.sv
module tb_timer_cmd_decoder;
   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0] addr = 2'b00;
   logic [7:0] din = 8'h00;
   logic [23:0] chan_rdata = 24'hC3_B2_A1;
   logic [7:0] rdata, wdata;
   logic rdata_oe, ctl_bcd;
   logic [2:0] chan_wr, chan_rd, prog, latch_cnt, latch_sts, ctl_mode;
   logic [1:0] ctl_access;

   int n_checks = 0, n_fail = 0;
   int cnt_wr[3], cnt_rd[3], cnt_prog[3], cnt_lc[3], cnt_ls[3];
   logic [7:0] seen_wdata;
   bit wide_pulse;

   always #2 clk = ~clk;

   timer_cmd_decoder dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .din(din), .chan_rdata(chan_rdata), .rdata(rdata),
      .rdata_oe(rdata_oe), .wdata(wdata), .chan_wr(chan_wr), .chan_rd(chan_rd),
      .prog(prog), .latch_cnt(latch_cnt), .latch_sts(latch_sts),
      .ctl_access(ctl_access), .ctl_mode(ctl_mode), .ctl_bcd(ctl_bcd));

   logic [14:0] prev_pulses = '0;
   always @(negedge clk) begin
      for (int i = 0; i < 3; i++) begin
         cnt_wr[i]   += int'(chan_wr[i]);
         cnt_rd[i]   += int'(chan_rd[i]);
         cnt_prog[i] += int'(prog[i]);
         cnt_lc[i]   += int'(latch_cnt[i]);
         cnt_ls[i]   += int'(latch_sts[i]);
      end
      if (|chan_wr) seen_wdata = wdata;
      if (|({chan_wr, chan_rd, prog, latch_cnt, latch_sts} & prev_pulses)) wide_pulse = 1;
      prev_pulses = {chan_wr, chan_rd, prog, latch_cnt, latch_sts};
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_counts();
      for (int i = 0; i < 3; i++) begin
         cnt_wr[i] = 0; cnt_rd[i] = 0; cnt_prog[i] = 0; cnt_lc[i] = 0; cnt_ls[i] = 0;
      end
      seen_wdata = 8'h00;
   endtask

   function automatic int pack(input int c[3]);
      return c[2] * 100 + c[1] * 10 + c[0];
   endfunction

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d,
                            input logic sel_n, input int hold);
      @(posedge clk); #1;
      cs_n = sel_n; addr = a; din = d; wr_n = 1'b0;
      repeat (hold) @(posedge clk);
      #1 wr_n = 1'b1;
      @(posedge clk); #1 cs_n = 1'b1;
      repeat (6) @(posedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check({chan_wr, chan_rd, prog, latch_cnt, latch_sts} == 15'd0 && wdata == 8'h00 &&
            ctl_mode == 3'd0 && ctl_access == 2'd0 && !ctl_bcd && !rdata_oe,
            "R11", "reset outputs", int'({prog, latch_cnt}), 0);
   endtask

   task automatic t_chan_writes();
      for (int k = 0; k < 3; k++) begin
         clear_counts();
         bus_write(2'(k), 8'h50 + 8'(k), 1'b0, 4);
         check(pack(cnt_wr) == (k == 0 ? 1 : k == 1 ? 10 : 100), "R1",
               "write pulse per channel", pack(cnt_wr), k);
         check(seen_wdata == 8'h50 + 8'(k), "R1", "write byte", seen_wdata, 8'h50 + k);
      end
   endtask

   task automatic t_long_strobe();
      clear_counts(); wide_pulse = 0;
      bus_write(2'd1, 8'h77, 1'b0, 40);
      check(pack(cnt_wr) == 10 && !wide_pulse, "R9", "held strobe single pulse",
            pack(cnt_wr), 10);
   endtask

   task automatic t_cs_high();
      clear_counts();
      bus_write(2'd0, 8'h11, 1'b1, 4);
      bus_write(2'd3, 8'h34, 1'b1, 4);
      check(pack(cnt_wr) + pack(cnt_prog) + pack(cnt_lc) == 0, "R2",
            "writes without select", pack(cnt_prog), 0);
      @(posedge clk); #1 addr = 2'd1; rd_n = 1'b0;
      repeat (4) @(negedge clk);
      check(!rdata_oe && rdata == 8'h00, "R2", "read without select", rdata_oe, 0);
      #1 rd_n = 1'b1;
      repeat (6) @(posedge clk);
      check(pack(cnt_rd) == 0, "R2", "read pulse without select", pack(cnt_rd), 0);
   endtask

   task automatic t_prog();
      clear_counts();
      bus_write(2'd3, 8'b10_11_111_1, 1'b0, 4);
      check(pack(cnt_prog) == 100 && pack(cnt_lc) == 0, "R4", "mode setup to ch2",
            pack(cnt_prog), 100);
      check(ctl_access == 2'b11 && ctl_bcd == 1'b1, "R4", "access and bcd",
            {ctl_access, ctl_bcd}, 7);
      check(ctl_mode == 3'd3, "R8", "mode 7 folded", ctl_mode, 3);
      clear_counts();
      bus_write(2'd3, 8'b00_01_110_0, 1'b0, 4);
      check(pack(cnt_prog) == 1 && ctl_mode == 3'd2 && ctl_access == 2'b01, "R8",
            "mode 6 folded on ch0", ctl_mode, 2);
      clear_counts();
      bus_write(2'd3, 8'b01_10_101_0, 1'b0, 4);
      check(pack(cnt_prog) == 10 && ctl_mode == 3'd5, "R8", "mode 5 kept",
            ctl_mode, 5);
   endtask

   task automatic t_latch();
      clear_counts();
      bus_write(2'd3, 8'b01_00_0000, 1'b0, 4);
      check(pack(cnt_lc) == 10 && pack(cnt_prog) == 0 && pack(cnt_ls) == 0, "R5",
            "count snapshot ch1", pack(cnt_lc), 10);
      check(ctl_mode == 3'd5, "R5", "snapshot leaves mode field", ctl_mode, 5);
   endtask

   task automatic t_readback();
      clear_counts();
      bus_write(2'd3, 8'b11_0_0_101_0, 1'b0, 4);
      check(pack(cnt_lc) == 101 && pack(cnt_ls) == 101 && pack(cnt_prog) == 0, "R6",
            "count+status ch2,ch0", pack(cnt_lc) * 1000 + pack(cnt_ls), 101101);
      clear_counts();
      bus_write(2'd3, 8'b11_1_0_010_0, 1'b0, 4);
      check(pack(cnt_lc) == 0 && pack(cnt_ls) == 10, "R6", "status only ch1",
            pack(cnt_ls), 10);
      clear_counts();
      bus_write(2'd3, 8'b11_0_1_111_0, 1'b0, 4);
      check(pack(cnt_lc) == 111 && pack(cnt_ls) == 0, "R6", "count only all",
            pack(cnt_lc), 111);
      clear_counts();
      bus_write(2'd3, 8'b11_1_1_111_0, 1'b0, 4);
      bus_write(2'd3, 8'b11_0_0_000_0, 1'b0, 4);
      check(pack(cnt_lc) + pack(cnt_ls) + pack(cnt_prog) == 0, "R7",
            "empty read-back", pack(cnt_lc) + pack(cnt_ls), 0);
   endtask

   task automatic t_reads();
      for (int k = 0; k < 4; k++) begin
         clear_counts();
         @(posedge clk); #1 cs_n = 1'b0; addr = 2'(k); rd_n = 1'b0;
         repeat (6) @(negedge clk);
         if (k < 3) begin
            check(rdata_oe && rdata == chan_rdata[k*8 +: 8], "R3", "read mux",
                  rdata, chan_rdata[k*8 +: 8]);
         end else begin
            check(!rdata_oe && rdata == 8'h00, "R3", "control read undriven", rdata_oe, 0);
         end
         check(pack(cnt_rd) == 0, "R10", "no pulse during strobe", pack(cnt_rd), 0);
         #1 rd_n = 1'b1;
         @(posedge clk); #1 cs_n = 1'b1;
         repeat (6) @(posedge clk);
         check(pack(cnt_rd) == (k == 0 ? 1 : k == 1 ? 10 : k == 2 ? 100 : 0), "R10",
               "consumed pulse after strobe", pack(cnt_rd), k);
      end
      @(negedge clk);
      check(!rdata_oe && rdata == 8'h00, "R3", "idle bus", rdata, 0);
   endtask

   initial begin
      clear_counts();
      repeat (3) @(posedge clk);
      t_reset();
      #1 rst_n = 1'b1;
      repeat (2) @(posedge clk);
      t_chan_writes();
      t_long_strobe();
      t_cs_high();
      t_prog();
      t_latch();
      t_readback();
      t_reads();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule